// File: doc/BRIEF.md
# Ethernet Transmit Short-Frame Padder

This block sits in a transmit datapath ahead of the checksum generator. It accepts outgoing Ethernet frames with no FCS on a 64-bit byte-enabled stream that uses valid, ready, tkeep and tlast. While a frame passes through, the block reads the tag protocol identifiers in the header. It then decides whether the frame carries no VLAN tag, one tag, or two stacked tags.

A frame whose header-plus-payload length is below the minimum for its tag class is extended with zero bytes. To do this, the block stalls the input after the frame's last beat, emits extra beats of zeros, and moves tlast to the final padded beat. A configuration bit turns padding on or off. Padding is only legal together with checksum insertion, so the block raises a configuration-error flag when padding is requested without it, and does not pad in that case. Frames that need no padding stream through at one beat per clock, behind a single output register.

Top module: `eth_tx_padder`

## Requirements
- R1: After reset, m_tvalid is low and s_tready is high.
- R2: A frame with no recognised tag is padded to 14 + MIN_PAY_UNTAG bytes (60 by default).
- R3: A frame whose bytes 12..13 hold TPID 0x8100 (byte 12 = 0x81, byte 13 = 0x00) and which is not stacked is padded to 18 + MIN_PAY_ONE bytes (60 by default). Frame byte k travels on lane k%8, which is bits 8*(k%8)+7..8*(k%8), of beat k/8.
- R4: A frame is stacked when bytes 12..13 hold 0x88A8 or 0x8100 and bytes 16..17 hold 0x8100. A stacked frame is padded to 22 + MIN_PAY_TWO bytes (60 by default). A frame with 0x88A8 and no inner 0x8100 counts as untagged. Header bytes that lie beyond the end of a frame never match.
- R5: Every pad byte is 0x00, including the unused lanes of the frame's original last beat. tkeep is contiguous from lane 0, and tlast appears only on the final padded beat.
- R6: A frame already at or above its required length leaves unchanged: same bytes, same length.
- R7: With cfg_pad_en = 0, every frame leaves unchanged, including undersized ones.
- R8: cfg_err is high exactly when cfg_pad_en = 1 and cfg_crc_ins = 0. While it is high, no frame is padded.
- R9: The padding decision uses the configuration present on a frame's first accepted beat. A change during the frame applies from the next frame.
- R10: While m_tvalid is high and m_tready is low, m_tvalid, m_tdata, m_tkeep and m_tlast hold their values.
- R11: With m_tready held high, a frame that needs no padding is accepted at one beat per clock, with s_tready never low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pad_en | input | 1 | Padding request bit (1 = pad) |
| cfg_crc_ins | input | 1 | Checksum insertion enabled downstream |
| cfg_err | output | 1 | Padding requested without checksum insertion |
| s_tdata | input | 64 | Input frame bytes |
| s_tkeep | input | 8 | Input byte enables, contiguous from lane 0 |
| s_tvalid | input | 1 | Input beat valid |
| s_tlast | input | 1 | Input beat ends the frame |
| s_tready | output | 1 | Block can take an input beat |
| m_tdata | output | 64 | Output frame bytes |
| m_tkeep | output | 8 | Output byte enables |
| m_tvalid | output | 1 | Output beat valid |
| m_tlast | output | 1 | Output beat ends the frame |
| m_tready | input | 1 | Downstream takes the output beat |

## Verification
The padding decision for a short frame's last beat can land in the same cycle as a downstream stall. Zero beats can also be emitted across stalls, while the next frame waits at the input. Frames of every length up to past the largest minimum, in every tag class, are driven with input gaps against an irregular m_tready pattern, so these stalls and pad decisions collide at every position in a frame. Each output frame is rebuilt from the enabled lanes and compared byte by byte with a model of frame length and tag class. Every stalled beat is also checked for stability on the next sample.

// File: rtl/eth_pad_pkg.sv
package eth_pad_pkg;

    typedef enum logic {
        PH_PASS = 1'b0,
        PH_PAD  = 1'b1
    } phase_e;

    // Tag sightings collected while a header streams past
    typedef struct packed {
        logic ctag_outer;   // 0x8100 at the first TPID slot
        logic any_outer;    // 0x8100 or 0x88A8 at the first TPID slot
        logic ctag_inner;   // 0x8100 at the second TPID slot
    } tag_flags_t;

    localparam logic [15:0] TPID_CTAG  = 16'h8100;
    localparam logic [15:0] TPID_STAG  = 16'h88A8;
    localparam int          OFF_TPID1  = 12;
    localparam int          OFF_TPID2  = 16;
    localparam int          HDR_PLAIN  = 14;
    localparam int          HDR_ONE    = 18;
    localparam int          HDR_TWO    = 22;

endpackage

// File: rtl/eth_pad_classify.sv
module eth_pad_classify
    import eth_pad_pkg::*;
#(
    parameter int CNT_W         = 16,
    parameter int MIN_PAY_UNTAG = 46,
    parameter int MIN_PAY_ONE   = 42,
    parameter int MIN_PAY_TWO   = 38
) (
    input  logic              slot1_hit,
    input  logic [15:0]       slot1_val,
    input  logic              slot2_hit,
    input  logic [15:0]       slot2_val,
    input  tag_flags_t        flags_q,
    output tag_flags_t        flags_d,
    output logic [CNT_W-1:0]  req_len
);

    localparam logic [CNT_W-1:0] REQ_UNTAG = CNT_W'(HDR_PLAIN + MIN_PAY_UNTAG);
    localparam logic [CNT_W-1:0] REQ_ONE   = CNT_W'(HDR_ONE + MIN_PAY_ONE);
    localparam logic [CNT_W-1:0] REQ_TWO   = CNT_W'(HDR_TWO + MIN_PAY_TWO);

    always_comb begin
        flags_d            = flags_q;
        flags_d.ctag_outer = flags_q.ctag_outer | (slot1_hit && slot1_val == TPID_CTAG);
        flags_d.any_outer  = flags_q.any_outer
                           | (slot1_hit && (slot1_val == TPID_CTAG || slot1_val == TPID_STAG));
        flags_d.ctag_inner = flags_q.ctag_inner | (slot2_hit && slot2_val == TPID_CTAG);

        if (flags_d.any_outer && flags_d.ctag_inner) begin
            req_len = REQ_TWO;
        end else if (flags_d.ctag_outer) begin
            req_len = REQ_ONE;
        end else begin
            req_len = REQ_UNTAG;
        end
    end

endmodule

// File: rtl/eth_pad_lanes.sv
module eth_pad_lanes #(
    parameter int BYTES = 8,
    parameter int CW    = 4
) (
    input  logic [8*BYTES-1:0] data_i,
    input  logic [BYTES-1:0]   keep_i,
    input  logic               pad,
    input  logic [CW-1:0]      span,
    output logic [8*BYTES-1:0] data_o,
    output logic [BYTES-1:0]   keep_o
);

    for (genvar l = 0; l < BYTES; l++) begin : g_lane
        // A padded beat covers lanes below span; lanes without input data become zero
        assign keep_o[l]         = pad ? (CW'(l) < span) : keep_i[l];
        assign data_o[8*l +: 8]  = (pad && !keep_i[l]) ? 8'h00 : data_i[8*l +: 8];
    end

endmodule

// File: rtl/eth_tx_padder.sv
module eth_tx_padder
    import eth_pad_pkg::*;
#(
    parameter int DATA_W        = 64,
    parameter int CNT_W         = 16,
    parameter int MIN_PAY_UNTAG = 46,
    parameter int MIN_PAY_ONE   = 42,
    parameter int MIN_PAY_TWO   = 38
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_pad_en,
    input  logic                cfg_crc_ins,
    output logic                cfg_err,
    input  logic [DATA_W-1:0]   s_tdata,
    input  logic [DATA_W/8-1:0] s_tkeep,
    input  logic                s_tvalid,
    input  logic                s_tlast,
    output logic                s_tready,
    output logic [DATA_W-1:0]   m_tdata,
    output logic [DATA_W/8-1:0] m_tkeep,
    output logic                m_tvalid,
    output logic                m_tlast,
    input  logic                m_tready
);

    localparam int BYTES = DATA_W / 8;
    localparam int CW    = $clog2(BYTES + 1);
    localparam int BW    = $clog2((OFF_TPID2 + 1) / BYTES + 2);
    localparam int S1_BEAT = OFF_TPID1 / BYTES;
    localparam int S1_LANE = OFF_TPID1 % BYTES;
    localparam int S2_BEAT = OFF_TPID2 / BYTES;
    localparam int S2_LANE = OFF_TPID2 % BYTES;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] BYTES_C = CNT_W'(BYTES);
    localparam logic [BW-1:0]    BEAT_MAX = '1;

    typedef struct packed {
        phase_e              phase;
        logic                ovalid;
        logic [DATA_W-1:0]   odata;
        logic [BYTES-1:0]    okeep;
        logic                olast;
        logic                ozero;
        logic [CNT_W-1:0]    cnt;
        logic [BW-1:0]       beat;
        tag_flags_t          flags;
        logic                sof;
        logic                pad_act;
        logic [CNT_W-1:0]    left;
    } st_t;

    st_t st_q, st_d;

    logic [CW-1:0]      n_in;
    logic [CNT_W:0]     total;
    logic               slot1_hit, slot2_hit;
    logic [15:0]        slot1_val, slot2_val;
    tag_flags_t         flags_nx;
    logic [CNT_W-1:0]   req_len;
    logic               pad_eff;
    logic               is_short;
    logic [CNT_W-1:0]   rem;
    logic               fits;
    logic [CW-1:0]      span_in;
    logic               pad_fits;
    logic [CW-1:0]      span_pad;
    logic [DATA_W-1:0]  a_data, z_data;
    logic [BYTES-1:0]   a_keep, z_keep;
    logic               out_free;
    logic               acc;

    // ---------------- header slot extraction ----------------
    assign slot1_hit = (st_q.beat == BW'(S1_BEAT)) && s_tkeep[S1_LANE + 1];
    assign slot1_val = {s_tdata[8*S1_LANE +: 8], s_tdata[8*(S1_LANE + 1) +: 8]};
    assign slot2_hit = (st_q.beat == BW'(S2_BEAT)) && s_tkeep[S2_LANE + 1];
    assign slot2_val = {s_tdata[8*S2_LANE +: 8], s_tdata[8*(S2_LANE + 1) +: 8]};

    eth_pad_classify #(
        .CNT_W         (CNT_W),
        .MIN_PAY_UNTAG (MIN_PAY_UNTAG),
        .MIN_PAY_ONE   (MIN_PAY_ONE),
        .MIN_PAY_TWO   (MIN_PAY_TWO)
    ) u_cls (
        .slot1_hit (slot1_hit),
        .slot1_val (slot1_val),
        .slot2_hit (slot2_hit),
        .slot2_val (slot2_val),
        .flags_q   (st_q.flags),
        .flags_d   (flags_nx),
        .req_len   (req_len)
    );

    // ---------------- length arithmetic ----------------
    always_comb begin
        n_in = '0;
        for (int l = 0; l < BYTES; l++) begin
            n_in = n_in + CW'(s_tkeep[l]);
        end
    end

    assign total    = {1'b0, st_q.cnt} + (CNT_W + 1)'(n_in);
    assign cfg_err  = cfg_pad_en & ~cfg_crc_ins;
    assign pad_eff  = st_q.sof ? (cfg_pad_en & cfg_crc_ins) : st_q.pad_act;
    assign is_short = pad_eff && s_tlast && (total < {1'b0, req_len});
    assign rem      = req_len - st_q.cnt;
    assign fits     = rem <= BYTES_C;
    assign span_in  = fits ? rem[CW-1:0] : CW'(BYTES);
    assign pad_fits = st_q.left <= BYTES_C;
    assign span_pad = pad_fits ? st_q.left[CW-1:0] : CW'(BYTES);

    eth_pad_lanes #(.BYTES(BYTES), .CW(CW)) u_fill_last (
        .data_i (s_tdata),
        .keep_i (s_tkeep),
        .pad    (is_short),
        .span   (span_in),
        .data_o (a_data),
        .keep_o (a_keep)
    );

    eth_pad_lanes #(.BYTES(BYTES), .CW(CW)) u_fill_zero (
        .data_i ('0),
        .keep_i ('0),
        .pad    (1'b1),
        .span   (span_pad),
        .data_o (z_data),
        .keep_o (z_keep)
    );

    // ---------------- handshake ----------------
    assign out_free = !st_q.ovalid || m_tready;
    assign s_tready = (st_q.phase == PH_PASS) && out_free;
    assign acc      = s_tvalid && s_tready;

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        if (st_q.ovalid && m_tready) begin
            st_d.ovalid = 1'b0;
        end

        if (acc) begin
            st_d.ovalid  = 1'b1;
            st_d.odata   = a_data;
            st_d.okeep   = a_keep;
            st_d.ozero   = 1'b0;
            st_d.olast   = is_short ? fits : s_tlast;
            st_d.pad_act = pad_eff;
            if (s_tlast) begin
                st_d.cnt   = '0;
                st_d.beat  = '0;
                st_d.flags = '0;
                st_d.sof   = 1'b1;
                if (is_short && !fits) begin
                    st_d.phase = PH_PAD;
                    st_d.left  = rem - BYTES_C;
                end
            end else begin
                st_d.cnt   = (total > {1'b0, CNT_MAX}) ? CNT_MAX : total[CNT_W-1:0];
                st_d.beat  = (st_q.beat == BEAT_MAX) ? st_q.beat : st_q.beat + 1'b1;
                st_d.flags = flags_nx;
                st_d.sof   = 1'b0;
            end
        end else if (st_q.phase == PH_PAD && out_free) begin
            st_d.ovalid = 1'b1;
            st_d.odata  = z_data;
            st_d.okeep  = z_keep;
            st_d.olast  = pad_fits;
            st_d.ozero  = 1'b1;
            st_d.left   = pad_fits ? '0 : st_q.left - BYTES_C;
            if (pad_fits) begin
                st_d.phase = PH_PASS;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.sof <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign m_tvalid = st_q.ovalid;
    assign m_tdata  = st_q.odata;
    assign m_tkeep  = st_q.okeep;
    assign m_tlast  = st_q.olast;

    // ---------------- assertions ----------------
    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tkeep) && $stable(m_tlast));

    // R5
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && st_q.ozero |-> m_tdata == '0);

    // R5
    keep_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> (m_tkeep != '0) && ((m_tkeep & (m_tkeep + 1'b1)) == '0));

    // R5
    pad_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_PAD) && ($past(st_q.phase) == PH_PASS) |-> $past(s_tvalid && s_tlast));

    // R8
    err_nopad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && s_tlast && st_q.sof && cfg_err |=> m_tvalid && m_tlast && (m_tkeep == $past(s_tkeep)));

endmodule

// File: tb/tb_eth_tx_padder.sv
`timescale 1ns/1ps
module tb_eth_tx_padder;

    localparam int NB = 8;
    localparam int MU = 46;
    localparam int M1 = 50;
    localparam int M2 = 54;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_pad_en, cfg_crc_ins;
    logic        cfg_err;
    logic [63:0] s_tdata;
    logic [7:0]  s_tkeep;
    logic        s_tvalid, s_tlast;
    logic        s_tready;
    logic [63:0] m_tdata;
    logic [7:0]  m_tkeep;
    logic        m_tvalid, m_tlast;
    logic        m_tready;

    always #4 clk = ~clk;

    eth_tx_padder #(
        .DATA_W(64), .CNT_W(16),
        .MIN_PAY_UNTAG(MU), .MIN_PAY_ONE(M1), .MIN_PAY_TWO(M2)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_pad_en(cfg_pad_en), .cfg_crc_ins(cfg_crc_ins), .cfg_err(cfg_err),
        .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tvalid(s_tvalid), .s_tlast(s_tlast),
        .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tvalid(m_tvalid), .m_tlast(m_tlast),
        .m_tready(m_tready)
    );

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_q[$];
    int         exp_len_q[$];
    string      exp_tag_q[$];
    bit         exp_pad_q[$];
    logic [7:0] fb [0:127];
    int  rdy_mode = 1;
    int  mon_cyc  = 0;
    int  stalls   = 0;
    bit  gaps     = 1'b1;

    function automatic void chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endfunction

    task automatic build(int len, int typ);
        for (int k = 0; k < 128; k++) fb[k] = 8'(k * 13 + len * 5 + 1);
        case (typ)
            0: begin fb[12] = 8'h08; fb[13] = 8'h00; end
            1: begin fb[12] = 8'h81; fb[13] = 8'h00; fb[16] = 8'h08; fb[17] = 8'h00; end
            2: begin fb[12] = 8'h88; fb[13] = 8'hA8; fb[16] = 8'h81; fb[17] = 8'h00; end
            3: begin fb[12] = 8'h81; fb[13] = 8'h00; fb[16] = 8'h81; fb[17] = 8'h00; end
            default: begin fb[12] = 8'h88; fb[13] = 8'hA8; fb[16] = 8'h08; fb[17] = 8'h00; end
        endcase
    endtask

    // tag class from the bytes actually present: 0 none, 1 single, 2 stacked
    function automatic int frame_class(int len);
        bit c1, o1, c2;
        c1 = (len >= 14) && fb[12] == 8'h81 && fb[13] == 8'h00;
        o1 = c1 || ((len >= 14) && fb[12] == 8'h88 && fb[13] == 8'hA8);
        c2 = (len >= 18) && fb[16] == 8'h81 && fb[17] == 8'h00;
        if (o1 && c2) return 2;
        if (c1) return 1;
        return 0;
    endfunction

    task automatic send(int len, int typ, bit pad_on, string ovr, bit toggle);
        int cls, req, olen, beats;
        bit padded;
        string tag;
        build(len, typ);
        cls    = frame_class(len);
        req    = (cls == 2) ? 22 + M2 : (cls == 1) ? 18 + M1 : 14 + MU;
        padded = pad_on && (len < req);
        olen   = padded ? req : len;
        if (ovr != "") tag = ovr;
        else if (padded) tag = (cls == 2) ? "R4" : (cls == 1) ? "R3" : "R2";
        else tag = pad_on ? "R6" : "R7";
        for (int k = 0; k < olen; k++) exp_q.push_back(k < len ? fb[k] : 8'h00);
        exp_len_q.push_back(olen);
        exp_tag_q.push_back(tag);
        exp_pad_q.push_back(padded);
        beats = (len + NB - 1) / NB;
        for (int bi = 0; bi < beats; bi++) begin
            if (gaps && ((bi + len) % 3 == 0)) begin
                @(negedge clk);
                s_tvalid = 1'b0;
            end
            @(negedge clk);
            if (toggle && bi == 1) cfg_pad_en = ~cfg_pad_en;
            s_tvalid = 1'b1;
            s_tlast  = (bi == beats - 1);
            for (int l = 0; l < NB; l++) begin
                if (bi * NB + l < len) begin
                    s_tdata[8*l +: 8] = fb[bi * NB + l];
                    s_tkeep[l] = 1'b1;
                end else begin
                    s_tdata[8*l +: 8] = 8'hEE;
                    s_tkeep[l] = 1'b0;
                end
            end
            #1;
            while (!s_tready) begin
                stalls++;
                @(negedge clk);
                #1;
            end
            @(posedge clk);
        end
    endtask

    task automatic idle_in();
        @(negedge clk);
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    task automatic drain();
        int t = 0;
        idle_in();
        while (exp_len_q.size() != 0 && t < 3000) begin
            @(posedge clk);
            t++;
        end
        chk(exp_len_q.size() == 0, "R6", "frames outstanding", exp_len_q.size(), 0);
    endtask

    // output monitor and downstream ready
    initial begin
        logic [7:0]  got[$];
        bit          hv;
        logic [63:0] hd;
        logic [7:0]  hk;
        logic        hl;
        int          el, mism;
        string       et;
        bit          ep;
        logic [7:0]  e;
        hv = 1'b0;
        m_tready = 1'b1;
        forever begin
            @(negedge clk);
            mon_cyc++;
            m_tready = (rdy_mode == 0) ? 1'b1 : ((mon_cyc % 5) != 2 && (mon_cyc % 7) != 3);
            #1;
            if (rst_n) begin
                if (hv) begin
                    // R10 held beat must not change
                    chk(m_tvalid && m_tdata == hd && m_tkeep == hk && m_tlast == hl,
                        "R10", "held beat stable", int'(m_tvalid), 1);
                end
                hv = m_tvalid && !m_tready;
                hd = m_tdata; hk = m_tkeep; hl = m_tlast;
                if (m_tvalid && m_tready) begin
                    for (int l = 0; l < NB; l++) if (m_tkeep[l]) got.push_back(m_tdata[8*l +: 8]);
                    if (m_tlast) begin
                        if (exp_len_q.size() == 0) begin
                            chk(1'b0, "R6", "unexpected frame length", got.size(), 0);
                        end else begin
                            el = exp_len_q.pop_front();
                            et = exp_tag_q.pop_front();
                            ep = exp_pad_q.pop_front();
                            chk(got.size() == el, et, "frame length", got.size(), el);
                            mism = 0;
                            for (int i = 0; i < el; i++) begin
                                e = exp_q.pop_front();
                                if (i >= got.size() || got[i] != e) mism++;
                            end
                            chk(mism == 0, ep ? "R5" : et, "byte mismatches", mism, 0);
                        end
                        got.delete();
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R11 watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cfg_pad_en  = 1'b1;
        cfg_crc_ins = 1'b1;
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
        s_tdata  = '0;
        s_tkeep  = '0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(m_tvalid == 1'b0, "R1", "m_tvalid after reset", int'(m_tvalid), 0);
        chk(s_tready == 1'b1, "R1", "s_tready after reset", int'(s_tready), 1);

        // padding on: all tag classes and lengths, with gaps and stalls
        chk(cfg_err == 1'b0, "R8", "cfg_err with both bits set", int'(cfg_err), 0);
        for (int typ = 0; typ < 5; typ++)
            for (int len = 1; len <= 84; len++)
                send(len, typ, 1'b1, "", 1'b0);
        drain();

        // padding off
        @(negedge clk);
        cfg_pad_en = 1'b0;
        #1;
        chk(cfg_err == 1'b0, "R8", "cfg_err with padding off", int'(cfg_err), 0);
        for (int typ = 0; typ < 5; typ++)
            for (int len = 1; len <= 70; len++)
                send(len, typ, 1'b0, "R7", 1'b0);
        drain();

        // padding requested without checksum insertion
        @(negedge clk);
        cfg_pad_en  = 1'b1;
        cfg_crc_ins = 1'b0;
        #1;
        chk(cfg_err == 1'b1, "R8", "cfg_err without checksum", int'(cfg_err), 1);
        for (int typ = 0; typ < 5; typ++)
            for (int len = 1; len <= 40; len++)
                send(len, typ, 1'b0, "R8", 1'b0);
        drain();
        @(negedge clk);
        cfg_crc_ins = 1'b1;
        #1;
        chk(cfg_err == 1'b0, "R8", "cfg_err cleared", int'(cfg_err), 0);

        // R9 mid-frame configuration changes
        send(20, 0, 1'b1, "R9", 1'b1);   // starts on, turned off mid-frame: padded
        send(20, 1, 1'b0, "R9", 1'b0);   // off from frame start: not padded
        send(20, 0, 1'b0, "R9", 1'b1);   // starts off, turned on mid-frame: not padded
        send(20, 3, 1'b1, "R9", 1'b0);   // on from frame start: padded
        drain();

        // R11 full-rate streaming of frames that need no padding
        rdy_mode = 0;
        gaps = 1'b0;
        for (int typ = 0; typ < 5; typ++)
            for (int len = 76; len <= 110; len += 3) begin
                stalls = 0;
                send(len, typ, 1'b1, "R6", 1'b0);
                chk(stalls == 0, "R11", "input stall cycles", stalls, 0);
            end
        drain();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule